// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Engine

This block is the device-side logic of a small serial nonvolatile memory that a host reaches over three wires: a chip select, a serial clock and a serial data input. A fourth line, the serial data output, is tri-stateable and is returned as a value plus an output-enable. All three inputs are brought into the single system clock domain and their edges are detected there. The storage is modelled as a plain register array. Cell physics, analog levels and retention are outside the model.

A host first raises chip select. It then clocks in a frame made of a start bit, a two-bit command code and an address. Write-type commands also carry a data word. Reads stream words back with the address moving on by itself. Commands that change the contents are gated by a program-enable latch and take effect when chip select falls. A self-timed busy counter, whose length is a parameter counted in system clocks, then runs. While it runs, the host can hold chip select high and poll the data output for busy or ready. A width-select input, sampled once after reset, chooses between a word-wide view and a byte-wide view of the same storage.

Top module: `ee3w_slave`

## Requirements
- R1: A frame begins at the first data-in 1 seen on a serial clock rising edge while chip select is high; zeros before it are ignored. The start bit is followed, MSB first, by a 2-bit code and then 10 address bits in word mode or 11 address bits in byte mode. Write-type frames then carry 16 (word mode) or 8 (byte mode) data bits, MSB first. Every bit is taken on the serial clock rising edge.
- R2: The width select is sampled on the first clock after reset. A high value selects word mode, with 1024 words of 16 bits. A low value selects byte mode, with 2048 bytes of 8 bits. Word w in word mode spans byte 2w (low half) and byte 2w+1 (high half).
- R3: Code 10 is a read. On the rising edge that takes the last address bit, data out is enabled and drives a 0 dummy bit. Each following rising edge then drives the next bit of the addressed word, MSB first.
- R4: After the last bit of a word, a read goes straight on with the next address, without a new header. After the highest address it wraps to address 0, for as long as chip select stays high.
- R5: The program-enable latch is cleared by reset. Code 00 with top address bits 11 sets it, and code 00 with top bits 00 clears it. While the latch is clear, these commands change nothing and start no busy period: code 11 (erase word), code 01 (write word), code 00 with top bits 10 (erase all) and code 00 with top bits 01 (write all). Reads work in either state.
- R6: Modifying commands take effect on the falling edge of chip select after a complete frame. A frame cut short by chip select falling changes nothing and starts no busy period.
- R7: Erasing sets the affected cells to all ones. A word write replaces the old contents with no erase needed beforehand. Write-all stores the given data in every location.
- R8: The busy period lasts WR_CYCLES system clocks from the start of an operation. While chip select is high and no new frame has begun, data out is driven low during the busy period and high once it ends.
- R9: Data out is not enabled while chip select is low, and it is not enabled while a header is being clocked in.
- R10: No new frame is accepted while the busy period runs. A complete frame sent during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| org_i | input | 1 | Width select: 1 word mode, 0 byte mode (sampled after reset) |
| cs_i | input | 1 | Chip select, asynchronous, active high |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for serial data out; 0 means high impedance |

## Verification
The assertions assume that every serial clock phase and every chip select level lasts several system clocks. They also assume that data in is stable across each serial clock rising edge, so that the synchronized copies of the three wires keep their relative order. The bench drives all three wires on falling system clock edges. It holds each serial clock phase for four system clocks and changes data in only when the serial clock falls. Chip select is moved only while the serial clock is low, with several clocks of margin on each side.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_DONE} st_e;
  typedef enum logic [2:0] {CM_NONE, CM_EWEN, CM_EWDS, CM_ERASE, CM_WRITE, CM_ERAL, CM_WRAL} cmd_e;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] SUB_EN   = 2'b11;
  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WRAL = 2'b01;
endpackage

// File: rtl/ee3w_sync.sv
module ee3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic cs_fall_o,
  output logic sk_rise_o,
  output logic di_o
);
  logic [2:0] chain_q [STAGES];
  logic       cs_prev_q, sk_prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= '0;
        else        chain_q[g] <= {di_i, sk_i, cs_i};
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= '0;
        else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_prev_q <= 1'b0;
      sk_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= chain_q[STAGES-1][0];
      sk_prev_q <= chain_q[STAGES-1][1];
    end

  assign cs_o      = chain_q[STAGES-1][0];
  assign sk_rise_o = chain_q[STAGES-1][1] & ~sk_prev_q;
  assign cs_fall_o = ~chain_q[STAGES-1][0] & cs_prev_q;
  assign di_o      = chain_q[STAGES-1][2];
endmodule

// File: rtl/ee3w_array.sv
module ee3w_array #(
  parameter int WADDR_W = 10,
  parameter int WORD_W  = 16
) (
  input  logic                 clk,
  input  logic                 wide_i,
  input  logic                 we_i,
  input  logic                 all_i,
  input  logic [WADDR_W:0]     waddr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [WADDR_W:0]     raddr_i,
  output logic [WORD_W-1:0]    rdata_o
);
  localparam int BYTE_W  = WORD_W / 2;
  localparam int BADDR_W = WADDR_W + 1;
  localparam int DEPTH   = 1 << BADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [WORD_W-1:BYTE_W] hi;
  logic [BYTE_W-1:0]      lo;

  assign hi = wdata_i[WORD_W-1:BYTE_W];
  assign lo = wdata_i[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (we_i) begin
      if (all_i) begin
        for (int i = 0; i < DEPTH; i++)
          mem[i] <= (wide_i && (i % 2 == 1)) ? hi : lo;
      end else if (wide_i) begin
        mem[{waddr_i[WADDR_W-1:0], 1'b1}] <= hi;
        mem[{waddr_i[WADDR_W-1:0], 1'b0}] <= lo;
      end else begin
        mem[waddr_i] <= lo;
      end
    end
  end

  assign rdata_o = wide_i ? {mem[{raddr_i[WADDR_W-1:0], 1'b1}], mem[{raddr_i[WADDR_W-1:0], 1'b0}]}
                          : {{BYTE_W{1'b0}}, mem[raddr_i]};
endmodule

// File: rtl/ee3w_timer.sv
module ee3w_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i && cnt_q == '0) cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign busy_o = (cnt_q != '0);

  // R8
  busy_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/ee3w_slave.sv
module ee3w_slave
  import ee3w_pkg::*;
#(
  parameter int WADDR_W   = 10,
  parameter int WORD_W    = 16,
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_i,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int BYTE_W  = WORD_W / 2;
  localparam int BADDR_W = WADDR_W + 1;
  localparam int CNT_W   = $clog2(2 + BADDR_W + WORD_W + 1);
  localparam int IDX_W   = $clog2(WORD_W);

  logic cs_lvl, cs_fall, sk_rise, di;
  logic busy, tmr_start, mem_we, mem_all;
  logic [WORD_W-1:0]  mem_wdata, rd_word;

  logic wide_q, org_ok_q;
  st_e  st_q, st_d;
  cmd_e cmd_q, cmd_d;
  logic [1:0]         op_q, op_d;
  logic [BADDR_W-1:0] addr_q, addr_d, ptr_q, ptr_d, addr_nx, ptr_mask;
  logic [WORD_W-1:0]  dat_q, dat_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, hdr_last, dat_last;
  logic [IDX_W-1:0]   bidx_q, bidx_d, dw_top;
  logic do_q, do_d, en_q, en_d, stat_q, stat_d;
  logic [1:0] sub;
  logic modify;

  ee3w_sync u_sync (
    .clk, .rst_n, .cs_i, .sk_i, .di_i,
    .cs_o(cs_lvl), .cs_fall_o(cs_fall), .sk_rise_o(sk_rise), .di_o(di)
  );

  ee3w_array #(.WADDR_W(WADDR_W), .WORD_W(WORD_W)) u_array (
    .clk, .wide_i(wide_q), .we_i(mem_we), .all_i(mem_all),
    .waddr_i(addr_q), .wdata_i(mem_wdata), .raddr_i(ptr_q), .rdata_o(rd_word)
  );

  ee3w_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk, .rst_n, .start_i(tmr_start), .busy_o(busy)
  );

  // mode-dependent limits
  assign hdr_last = wide_q ? CNT_W'(WADDR_W + 1) : CNT_W'(BADDR_W + 1);
  assign dw_top   = wide_q ? IDX_W'(WORD_W - 1)  : IDX_W'(BYTE_W - 1);
  assign dat_last = CNT_W'(dw_top);
  assign ptr_mask = wide_q ? {1'b0, {WADDR_W{1'b1}}} : {BADDR_W{1'b1}};
  assign addr_nx  = {addr_q[BADDR_W-2:0], di};
  assign sub      = wide_q ? addr_nx[WADDR_W-1 -: 2] : addr_nx[BADDR_W-1 -: 2];
  assign modify   = (cmd_q == CM_ERASE) || (cmd_q == CM_WRITE) ||
                    (cmd_q == CM_ERAL)  || (cmd_q == CM_WRAL);

  always_comb begin
    st_d = st_q;   cmd_d = cmd_q;  op_d = op_q;     addr_d = addr_q;
    ptr_d = ptr_q; dat_d = dat_q;  cnt_d = cnt_q;   bidx_d = bidx_q;
    do_d = do_q;   en_d = en_q;    stat_d = stat_q;
    mem_we = 1'b0; mem_all = 1'b0; tmr_start = 1'b0;
    mem_wdata = (cmd_q == CM_WRITE || cmd_q == CM_WRAL) ? dat_q : '1;
    if (cs_fall) begin
      st_d = ST_IDLE;
      if (st_q == ST_DONE) begin
        if (cmd_q == CM_EWEN) en_d = 1'b1;
        if (cmd_q == CM_EWDS) en_d = 1'b0;
        if (modify && en_q) begin
          mem_we    = 1'b1;
          mem_all   = (cmd_q == CM_ERAL) || (cmd_q == CM_WRAL);
          tmr_start = 1'b1;
          stat_d    = 1'b1;
        end
      end
    end else if (sk_rise && cs_lvl) begin
      unique case (st_q)
        ST_IDLE: if (di && !busy && org_ok_q) begin
          st_d = ST_HDR; cnt_d = '0; op_d = '0; addr_d = '0;
          stat_d = 1'b0; cmd_d = CM_NONE;
        end
        ST_HDR: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q < CNT_W'(2)) op_d = {op_q[0], di};
          else                   addr_d = addr_nx;
          if (cnt_q == hdr_last) begin
            cnt_d = '0;
            unique case (op_q)
              OP_READ:  begin
                st_d = ST_READ; ptr_d = addr_nx; do_d = 1'b0; bidx_d = dw_top;
              end
              OP_WRITE: begin st_d = ST_DATA; cmd_d = CM_WRITE; end
              OP_ERASE: begin st_d = ST_DONE; cmd_d = CM_ERASE; end
              default: unique case (sub)
                SUB_EN:   begin st_d = ST_DONE; cmd_d = CM_EWEN; end
                SUB_DIS:  begin st_d = ST_DONE; cmd_d = CM_EWDS; end
                SUB_ERAL: begin st_d = ST_DONE; cmd_d = CM_ERAL; end
                default:  begin st_d = ST_DATA; cmd_d = CM_WRAL; end
              endcase
            endcase
          end
        end
        ST_DATA: begin
          dat_d = {dat_q[WORD_W-2:0], di};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == dat_last) st_d = ST_DONE;
        end
        ST_READ: begin
          do_d = rd_word[bidx_q];
          if (bidx_q == '0) begin
            bidx_d = dw_top;
            ptr_d  = (ptr_q + 1'b1) & ptr_mask;
          end else begin
            bidx_d = bidx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      org_ok_q <= 1'b0;
      wide_q   <= 1'b1;
    end else if (!org_ok_q) begin
      org_ok_q <= 1'b1;
      wide_q   <= org_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= ST_IDLE; cmd_q <= CM_NONE; op_q <= '0; addr_q <= '0;
      ptr_q <= '0; dat_q <= '0; cnt_q <= '0; bidx_q <= '0;
      do_q <= 1'b0; en_q <= 1'b0; stat_q <= 1'b0;
    end else begin
      st_q <= st_d; cmd_q <= cmd_d; op_q <= op_d; addr_q <= addr_d;
      ptr_q <= ptr_d; dat_q <= dat_d; cnt_q <= cnt_d; bidx_q <= bidx_d;
      do_q <= do_d; en_q <= en_d; stat_q <= stat_d;
    end

  assign do_oe_o = cs_lvl && ((st_q == ST_READ) || (st_q == ST_IDLE && stat_q));
  assign do_o    = (st_q == ST_READ) ? do_q : ~busy;

  // R9
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe_o |-> cs_lvl);
  // R10
  busy_blocks_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q == ST_IDLE) |=> st_q == ST_IDLE);
  // R5
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_q));
  // R3
  read_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ) |-> (bidx_q <= dw_top));
endmodule

// File: tb/ee3w_slave_bench.sv
module ee3w_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int BUSY_CYC   = 600;

  logic clk = 1'b0, rst_n = 1'b0, org = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_v, do_oe;
  int   n_chk = 0, n_fail = 0;
  bit   wide = 1'b1;

  logic [7:0]  bm [2048];
  logic [15:0] exp_v [$];
  string       exp_tag [$];
  logic [15:0] got_word;
  event        got_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee3w_slave #(.WR_CYCLES(BUSY_CYC)) u_ee3w_slave (
    .clk, .rst_n, .org_i(org), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_v), .do_oe_o(do_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected words and compares with what the read task saw
  initial forever begin
    @(got_ev);
    if (exp_v.size() == 0) chk(1'b0, "scoreboard-empty", got_word, 0);
    else begin
      automatic logic [15:0] e = exp_v.pop_front();
      automatic string t = exp_tag.pop_front();
      chk(got_word === e, t, got_word, e);
    end
  end

  // reference model
  task automatic m_wr(input int a, input logic [15:0] d);
    if (wide) begin bm[2*a+1] = d[15:8]; bm[2*a] = d[7:0]; end
    else bm[a] = d[7:0];
  endtask
  task automatic m_all(input logic [15:0] d);
    for (int i = 0; i < 2048; i++) bm[i] = (wide && i % 2 == 1) ? d[15:8] : d[7:0];
  endtask
  function automatic logic [15:0] m_get(input int a);
    return wide ? {bm[2*a+1], bm[2*a]} : {8'h00, bm[a]};
  endfunction

  task automatic sk_bit(input logic b);
    @(negedge clk); di = b;
    repeat (HALF) @(negedge clk); sk = 1'b1;
    repeat (HALF) @(negedge clk); sk = 1'b0;
  endtask
  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask
  task automatic cs_up();   @(negedge clk); cs = 1'b1; repeat (4) @(negedge clk); endtask
  task automatic cs_down(); repeat (2) @(negedge clk); cs = 1'b0; repeat (6) @(negedge clk); endtask
  task automatic hdr(input logic [1:0] op, input int a);
    send(1, 1); send({30'd0, op}, 2); send(a, wide ? 10 : 11);
  endtask
  task automatic ctl(input logic [1:0] sub);   // code 00 family
    cs_up(); hdr(2'b00, wide ? {sub, 8'h00} : {sub, 9'h000}); cs_down();
  endtask
  task automatic wr(input int a, input logic [15:0] d);
    cs_up(); hdr(2'b01, a); send(d, wide ? 16 : 8); cs_down();
  endtask
  task automatic wait_ready(input string req, input int lo, input int hi);
    int n = 0;
    cs_up();
    while (!(do_oe && do_v) && n < 4 * BUSY_CYC) begin @(negedge clk); n++; end
    chk(do_oe && do_v && n >= lo && n <= hi, req, n, hi);
    cs_down();
  endtask
  task automatic rd(input int a, input int words, input int lead, input string req);
    cs_up();
    send(0, lead);
    hdr(2'b10, a);
    chk(do_oe === 1'b1 && do_v === 1'b0, {req, " dummy"}, {do_oe, do_v}, 2'b10);
    for (int k = 0; k < words; k++) begin
      automatic logic [15:0] w = '0;
      exp_v.push_back(m_get((a + k) % (wide ? 1024 : 2048)));
      exp_tag.push_back(req);
      for (int b = 0; b < (wide ? 16 : 8); b++) begin
        sk_bit(1'b0);
        w = {w[14:0], do_v};
      end
      got_word = w; ->got_ev; @(negedge clk);
    end
    cs_down();
  endtask
  task automatic do_reset(input logic o);
    @(negedge clk); rst_n = 1'b0; org = o; wide = o;
    repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // R9: not driven at reset nor with cs high and idle
    chk(do_oe === 1'b0, "R9 reset oe", do_oe, 0);
    cs_up(); chk(do_oe === 1'b0, "R9 idle oe", do_oe, 0);
    send(1, 1); send(2'b10, 2); send(5, 5);
    chk(do_oe === 1'b0, "R9 oe during header", do_oe, 0);
    cs_down();

    // R8 R7: enable, erase all, busy then ready
    ctl(2'b11);
    cs_up(); hdr(2'b00, 10'h200); cs_down(); m_all(16'hFFFF);
    cs_up(); repeat (6) @(negedge clk);
    chk(do_oe === 1'b1 && do_v === 1'b0, "R8 busy low", {do_oe, do_v}, 2'b10);
    cs_down();
    wait_ready("R8 ready after busy", BUSY_CYC - 60, BUSY_CYC);
    rd(5, 1, 0, "R7 erase-all ones");

    // R5: after reset latch is clear, modifications ignored
    do_reset(1'b1);
    wr(3, 16'h1234);
    cs_up(); chk(do_oe === 1'b0, "R5 no busy when disabled", do_oe, 0); cs_down();
    cs_up(); hdr(2'b00, 10'h100); send(16'h0000, 16); cs_down();
    rd(3, 1, 0, "R5 write/wral ignored");

    // R7 R1 R4: enable, writes, streaming read
    ctl(2'b11);
    wr(3, 16'hA5C3); m_wr(3, 16'hA5C3); wait_ready("R8 write ready", 0, BUSY_CYC);
    wr(4, 16'h0F0F); m_wr(4, 16'h0F0F); wait_ready("R8 write ready", 0, BUSY_CYC);
    rd(3, 2, 3, "R4 autoincrement R1 leading zeros");
    wr(3, 16'h5AA5); m_wr(3, 16'h5AA5); wait_ready("R8 write ready", 0, BUSY_CYC);
    rd(3, 1, 0, "R7 overwrite without erase");

    // R4 wrap
    wr(0, 16'h0102); m_wr(0, 16'h0102); wait_ready("R8 write ready", 0, BUSY_CYC);
    wr(1023, 16'hBEEF); m_wr(1023, 16'hBEEF); wait_ready("R8 write ready", 0, BUSY_CYC);
    rd(1023, 2, 0, "R4 wrap");

    // R7 single erase
    cs_up(); hdr(2'b11, 4); cs_down(); m_wr(4, 16'hFFFF);
    wait_ready("R8 erase ready", 0, BUSY_CYC);
    rd(4, 1, 0, "R7 erase word");

    // R6 aborted frame
    cs_up(); hdr(2'b01, 9); send(8'h00, 8); cs_down();
    cs_up(); chk(do_oe === 1'b0, "R6 abort no busy", do_oe, 0); cs_down();
    rd(9, 1, 0, "R6 abort unchanged");

    // R10 frame during busy ignored
    wr(7, 16'h1111); m_wr(7, 16'h1111);
    wr(8, 16'h2222);
    wait_ready("R8 ready", 0, BUSY_CYC);
    rd(7, 2, 0, "R10 frame during busy ignored");

    // R5 disable then write ignored
    ctl(2'b00);
    wr(7, 16'h3333);
    rd(7, 1, 0, "R5 disabled write ignored");
    ctl(2'b11);

    // R7 write all
    cs_up(); hdr(2'b00, 10'h100); send(16'h5A3C, 16); cs_down(); m_all(16'h5A3C);
    wait_ready("R8 wral ready", 0, BUSY_CYC);
    rd(100, 1, 0, "R7 write all");

    // R2 byte mode
    do_reset(1'b0);
    ctl(2'b11);
    wr(2047, 16'h003C); m_wr(2047, 16'h003C); wait_ready("R8 byte ready", 0, BUSY_CYC);
    wr(0, 16'h0081); m_wr(0, 16'h0081); wait_ready("R8 byte ready", 0, BUSY_CYC);
    rd(2047, 2, 0, "R2 byte mode R4 wrap");
    rd(1, 1, 0, "R2 byte mode layout");

    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule